// File: doc/BRIEF.md
# Upset-Injectable Byte Register File

This block is the byte storage of a small processor: a lower bank of general data bytes followed by an upper bank of special-function register bytes, all in one flat address space. Host logic reaches it through an ordinary port that writes on the clock edge and returns read data one cycle later.

A second port models single-event upsets. When its strobe is high at a clock edge, the byte named by the upset address has the bit named by the bit index inverted at that edge. This port does not wait on the host port and does not depend on what it is doing. It can land on the same byte as a host write in the same cycle. Upset addresses past the last byte are refused and flagged. Accepted upsets are counted so that a fault campaign can tell how many flips reached storage.

Top module: `upset_regfile`

## Requirements
- R1: A host write with `wr_en` high stores `wr_data` at `wr_addr` on the clock edge. `rd_data` shows the byte held at `rd_addr` just before an edge and updates on that edge, so reads have one cycle of latency.
- R2: When `inj_stb` is high at an edge and `inj_addr` is below `RAM_BYTES + SFR_BYTES`, bit `inj_bit` of that byte is inverted at that edge. Bit 0 is the least significant bit. The flipped value can be read in the next cycle. A second upset on the same bit restores the original value.
- R3: One accepted strobe changes exactly one stored bit. No other bit of that byte changes, and no other byte changes.
- R4: If a host write and an accepted upset hit the same byte at the same edge, the byte stores `wr_data` with bit `inj_bit` inverted.
- R5: An upset whose address is at or above `RAM_BYTES + SFR_BYTES` changes no byte. `inj_err` is high for exactly the one cycle after that edge. At all other times `inj_err` is low.
- R6: `inj_count` goes up by one for each accepted upset and holds at all ones once it gets there. Refused upsets leave it unchanged.
- R7: With `inj_stb` low, the stored bytes change only through host writes.
- R8: A read of a byte at the same edge as an upset to that byte returns the value from before the flip. The upset acts only on storage, not on read data already on its way out.
- R9: While `rst_n` is low, every byte, `rd_data`, `inj_count` and `inj_err` are zero. Any upset requested during reset is dropped.
- R10: A host write to an address at or above `RAM_BYTES + SFR_BYTES` changes no byte. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | AW | Host write byte address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | AW | Host read byte address |
| rd_data | output | 8 | Registered read data |
| inj_stb | input | 1 | Upset strobe |
| inj_addr | input | AW | Byte address for the upset |
| inj_bit | input | 3 | Bit index for the upset |
| inj_err | output | 1 | One-cycle flag for a refused upset address |
| inj_count | output | CNT_W | Saturating count of accepted upsets |

## Verification
The bench keeps the default 128 data bytes and 24 special-function bytes, which gives 152 targets and an 8-bit address. This reaches both edges of the valid range (151 and 152) and leaves unused address codes up to 255 for refused writes and upsets. It builds the counter with `CNT_W` set to 4, so the saturation point of 15 is reached within a few dozen upsets. The table covers a host write colliding with an upset, a read in the same cycle as an upset, and a bit flipped back by a second upset.

// File: rtl/upset_pkg.sv
package upset_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t bit_mask(input logic [BIT_W-1:0] idx);
    byte_t m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/upset_target_dec.sv
module upset_target_dec
  import upset_pkg::*;
#(
  parameter int TOTAL = 152,
  parameter int AW    = 8
) (
  input  logic             inj_stb,
  input  logic [AW-1:0]    inj_addr,
  input  logic [BIT_W-1:0] inj_bit,
  output logic             accept,
  output logic             refuse,
  output byte_t            mask,
  output logic [TOTAL-1:0] word_sel
);
  localparam logic [AW:0] LIMIT = (AW+1)'(TOTAL);

  logic in_range;

  always_comb begin
    in_range = {1'b0, inj_addr} < LIMIT;
    accept   = inj_stb && in_range;
    refuse   = inj_stb && !in_range;
    mask     = bit_mask(inj_bit);
  end

  for (genvar gi = 0; gi < TOTAL; gi++) begin : g_sel
    assign word_sel[gi] = inj_stb && (inj_addr == AW'(gi));
  end
endmodule

// File: rtl/upset_word_array.sv
module upset_word_array
  import upset_pkg::*;
#(
  parameter int TOTAL = 152,
  parameter int AW    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  byte_t                   wr_data,
  input  logic [TOTAL-1:0]        inj_sel,
  input  byte_t                   inj_mask,
  input  logic [AW-1:0]           rd_addr,
  output byte_t                   rd_data,
  output logic [TOTAL*BYTE_W-1:0] words_flat
);
  localparam logic [AW:0] LIMIT = (AW+1)'(TOTAL);

  byte_t words [TOTAL];

  for (genvar gi = 0; gi < TOTAL; gi++) begin : g_word
    logic  wr_hit;
    logic  en;
    byte_t nxt;

    always_comb begin
      wr_hit = wr_en && (wr_addr == AW'(gi));
      en     = wr_hit || inj_sel[gi];
      nxt    = (wr_hit ? wr_data : words[gi]) ^ (inj_sel[gi] ? inj_mask : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  words[gi] <= '0;
      else if (en) words[gi] <= nxt;
    end

    assign words_flat[gi*BYTE_W +: BYTE_W] = words[gi];
  end

  byte_t rd_nxt;

  always_comb begin
    if ({1'b0, rd_addr} < LIMIT) rd_nxt = words[rd_addr];
    else                         rd_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_nxt;
  end
endmodule

// File: rtl/upset_sat_count.sv
module upset_sat_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic         en;
  logic [W-1:0] nxt;

  always_comb begin
    en  = inc && (count != {W{1'b1}});
    nxt = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count <= '0;
    else if (en) count <= nxt;
  end
endmodule

// File: rtl/upset_regfile.sv
module upset_regfile
  import upset_pkg::*;
#(
  parameter int RAM_BYTES = 128,
  parameter int SFR_BYTES = 24,
  parameter int CNT_W     = 8,
  localparam int TOTAL    = RAM_BYTES + SFR_BYTES,
  localparam int AW       = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  input  logic             inj_stb,
  input  logic [AW-1:0]    inj_addr,
  input  logic [2:0]       inj_bit,
  output logic             inj_err,
  output logic [CNT_W-1:0] inj_count
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic             accept;
  logic             refuse;
  byte_t            mask;
  logic [TOTAL-1:0] word_sel;
  logic [TOTAL*BYTE_W-1:0] words_flat;

  upset_target_dec #(.TOTAL(TOTAL), .AW(AW)) i_dec (
    .inj_stb  (inj_stb),
    .inj_addr (inj_addr),
    .inj_bit  (inj_bit),
    .accept   (accept),
    .refuse   (refuse),
    .mask     (mask),
    .word_sel (word_sel)
  );

  upset_word_array #(.TOTAL(TOTAL), .AW(AW)) i_array (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .inj_sel    (word_sel),
    .inj_mask   (mask),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .words_flat (words_flat)
  );

  upset_sat_count #(.W(CNT_W)) i_count (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (accept),
    .count (inj_count)
  );

  logic err_nxt;
  always_comb err_nxt = refuse;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) inj_err <= 1'b0;
    else             inj_err <= err_nxt;
  end
endmodule

// File: rtl/upset_regfile_chk.sv
module upset_regfile_chk #(
  parameter int TOTAL = 152,
  parameter int AW    = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [7:0]       wr_data,
  input logic [AW-1:0]    rd_addr,
  input logic [7:0]       rd_data,
  input logic             inj_stb,
  input logic [AW-1:0]    inj_addr,
  input logic [2:0]       inj_bit,
  input logic             inj_err,
  input logic [CNT_W-1:0] inj_count,
  input logic [TOTAL*8-1:0] words_flat
);
  logic good_inj;
  logic bad_inj;
  assign good_inj = inj_stb && (int'(inj_addr) < TOTAL);
  assign bad_inj  = inj_stb && (int'(inj_addr) >= TOTAL);

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(rd_addr) < TOTAL) |=> rd_data == $past(words_flat[int'(rd_addr)*8 +: 8]));

  assert_single_flip_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (good_inj && !wr_en) |=> $countones(words_flat ^ $past(words_flat)) == 1);

  assert_collision_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (good_inj && wr_en && wr_addr == inj_addr) |=>
      words_flat[int'($past(inj_addr))*8 +: 8] == ($past(wr_data) ^ (8'd1 << $past(inj_bit))));

  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bad_inj |=> inj_err);

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bad_inj |=> !inj_err);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (good_inj && inj_count != {CNT_W{1'b1}}) |=> inj_count == $past(inj_count) + 1'b1);

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !good_inj |=> $stable(inj_count));

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!inj_stb && !wr_en) |=> $stable(words_flat));

  assert_bad_write_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!inj_stb && wr_en && int'(wr_addr) >= TOTAL) |=> $stable(words_flat));
endmodule

bind upset_regfile upset_regfile_chk #(.TOTAL(TOTAL), .AW(AW), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .inj_stb    (inj_stb),
  .inj_addr   (inj_addr),
  .inj_bit    (inj_bit),
  .inj_err    (inj_err),
  .inj_count  (inj_count),
  .words_flat (words_flat)
);

// File: tb/test_upset_regfile.sv
module test_upset_regfile;
  localparam int NB    = 152;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic       we;
    logic [7:0] wa;
    logic [7:0] wd;
    logic       is;
    logic [7:0] ia;
    logic [2:0] ib;
    logic [7:0] ra;
  } vec_t;

  // we, wa, wd, is, ia, ib, ra
  localparam vec_t TBL [16] = '{
    '{1'b1, 8'd5,   8'hA5, 1'b0, 8'd0,   3'd0, 8'd5},   // R1 write
    '{1'b0, 8'd0,   8'h00, 1'b1, 8'd5,   3'd0, 8'd5},   // R2 flip bit 0
    '{1'b0, 8'd0,   8'h00, 1'b0, 8'd0,   3'd0, 8'd5},   // R2 read flipped
    '{1'b0, 8'd0,   8'h00, 1'b1, 8'd5,   3'd0, 8'd5},   // R8 read with flip
    '{1'b0, 8'd0,   8'h00, 1'b0, 8'd0,   3'd0, 8'd5},   // R2 restored
    '{1'b1, 8'd130, 8'h3C, 1'b1, 8'd130, 3'd7, 8'd130}, // R4 collision
    '{1'b0, 8'd0,   8'h00, 1'b0, 8'd0,   3'd0, 8'd130},
    '{1'b0, 8'd0,   8'h00, 1'b1, 8'd152, 3'd2, 8'd151}, // R5 first bad
    '{1'b1, 8'd151, 8'hFF, 1'b1, 8'd151, 3'd3, 8'd151}, // R4 last byte
    '{1'b0, 8'd0,   8'h00, 1'b0, 8'd0,   3'd0, 8'd151},
    '{1'b1, 8'd200, 8'h11, 1'b1, 8'd255, 3'd0, 8'd200}, // R10, R5
    '{1'b0, 8'd0,   8'h00, 1'b0, 8'd0,   3'd0, 8'd72},
    '{1'b1, 8'd9,   8'h5A, 1'b1, 8'd0,   3'd6, 8'd9},   // R3 separate bytes
    '{1'b0, 8'd0,   8'h00, 1'b0, 8'd0,   3'd0, 8'd0},
    '{1'b1, 8'd0,   8'h81, 1'b0, 8'd0,   3'd0, 8'd9},   // R7 plain write
    '{1'b0, 8'd0,   8'h00, 1'b0, 8'd0,   3'd0, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       inj_stb;
  logic [7:0] inj_addr;
  logic [2:0] inj_bit;
  logic       inj_err;
  logic [CNT_W-1:0] inj_count;

  always #5 clk = ~clk;

  upset_regfile #(.RAM_BYTES(128), .SFR_BYTES(24), .CNT_W(CNT_W)) i_upset_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .inj_stb   (inj_stb),
    .inj_addr  (inj_addr),
    .inj_bit   (inj_bit),
    .inj_err   (inj_err),
    .inj_count (inj_count)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] mdl [NB];
  int         mdl_cnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NB; i++) mdl[i] = 8'h00;
    mdl_cnt = 0;
  endtask

  // drive at negedge, edge, check at next negedge
  task automatic step(input vec_t v);
    logic [7:0] exp_rd;
    bit         exp_err;
    exp_rd  = (int'(v.ra) < NB) ? mdl[v.ra] : 8'h00;
    exp_err = v.is && (int'(v.ia) >= NB);
    if (v.we && int'(v.wa) < NB) mdl[v.wa] = v.wd;
    if (v.is && int'(v.ia) < NB) begin
      mdl[v.ia] = mdl[v.ia] ^ (8'd1 << v.ib);
      if (mdl_cnt < (1 << CNT_W) - 1) mdl_cnt++;
    end
    wr_en = v.we; wr_addr = v.wa; wr_data = v.wd;
    inj_stb = v.is; inj_addr = v.ia; inj_bit = v.ib; rd_addr = v.ra;
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == exp_rd, "R1 read data", rd_data, exp_rd);
    chk(inj_err == exp_err, "R5 refused flag", inj_err, exp_err);
    chk(int'(inj_count) == mdl_cnt, "R6 upset count", inj_count, mdl_cnt);
    wr_en = 1'b0; inj_stb = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] e, input string tag);
    wr_en = 1'b0; inj_stb = 1'b0; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == e, tag, rd_data, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(rd_data == 8'h00, "R9 rd_data in reset", rd_data, 0);
    chk(inj_err == 1'b0, "R9 inj_err in reset", inj_err, 0);
    chk(inj_count == '0, "R9 inj_count in reset", inj_count, 0);
    inj_stb = 1'b1; inj_addr = 8'd3; inj_bit = 3'd1; // dropped during reset
    repeat (2) @(negedge clk);
    inj_stb = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; inj_stb = 1'b0; inj_addr = '0; inj_bit = '0;
    model_clear();
    do_reset();
    rd_check(8'd3, 8'h00, "R9 upset in reset dropped");

    foreach (TBL[k]) step(TBL[k]);

    // directed readbacks with constant expectations
    rd_check(8'd5,   8'hA5, "R2 double flip restores");
    rd_check(8'd130, 8'hBC, "R4 write with bit 7 flipped");
    rd_check(8'd151, 8'hF7, "R4 last byte write with bit 3 flipped");
    rd_check(8'd72,  8'h00, "R10 refused write no alias");
    rd_check(8'd200, 8'h00, "R10 out of range read");
    rd_check(8'd9,   8'h5A, "R3 other byte untouched");
    rd_check(8'd0,   8'h81, "R7 host write over flipped byte");
    rd_check(8'd1,   8'h00, "R7 idle byte unchanged");

    // saturation: 12 more flips of byte 2 bit 1
    for (int k = 0; k < 12; k++) step('{1'b0, 8'd0, 8'h00, 1'b1, 8'd2, 3'd1, 8'd2});
    chk(inj_count == 4'hF, "R6 saturated", inj_count, 15);
    rd_check(8'd2, 8'h00, "R3 even flips cancel");

    // reset mid-run
    do_reset();
    rd_check(8'd130, 8'h00, "R9 byte cleared");
    chk(inj_count == '0, "R9 count cleared", inj_count, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule